// File: doc/BRIEF.md
# Translation Table Index Extractor

This block prepares the work of a multi-level page table walker. Given a translation control word, a 32-bit logical address, a 3-bit function code and a root limit, it cuts the address into the index used at each level of the translation tree. It also separates out the untranslated page offset, works out which level holds the page descriptors, and checks the first address index against the root limit.

The control word holds five things: a count of high address bits to drop, a page offset width, a flag that adds a top level indexed by the function code, and four index widths. A zero width ends the tree at that level.

After a start strobe the block captures all of its inputs. It then presents the levels one per clock, from the top of the tree down, in the order a walker consumes them. The page-table level is marked as the last one. If the control word does not describe exactly 32 address bits, the block raises an error pulse and presents no levels.

Top module: `tt_index_sequencer`

## Requirements
- R1: A start seen while idle makes `lvl_valid_o` rise one clock later. Levels are then presented one per clock, with `lvl_num_o` increasing by one each clock. `lvl_valid_o` falls on the clock after the last level. Level number 0 is the function-code level; levels 1 to 4 are the address-indexed levels.
- R2: When `cfg_fcl_i` is 1 at start, the first level presented is level 0. Its index equals the captured function code, zero-extended. When `cfg_fcl_i` is 0, the sequence starts at level 1.
- R3: Address level k takes `w_k` bits, where `w_k` is held in `cfg_widths_i[4k-1:4k-4]` (level 1 in bits 3:0). Those bits lie directly below the `cfg_ishift_i` dropped top bits and the bits taken by levels 1 to k-1. The index is right-aligned in `lvl_index_o`.
- R4: The first zero width ends the tree. Every width above it is ignored, even when nonzero.
- R5: `lvl_last_o` is 1 only while the page-table level is presented. That level is the one named by the last nonzero width. `final_lvl_o` gives its number throughout the sequence.
- R6: While levels are presented, `page_offset_o` holds the low `cfg_pgsz_i` bits of the captured address, zero-extended. It stays constant for the whole sequence.
- R7: `limit_viol_o` is 1 only during level 1, and only when the level 1 index is strictly greater than `root_limit_i`. An index equal to the limit does not set it.
- R8: A configuration is invalid if any of the following holds:
  - `cfg_pgsz_i` is below 8;
  - the level 1 width is zero;
  - `cfg_ishift_i`, `cfg_pgsz_i` and the active widths do not sum to 32.
  An invalid configuration makes `cfg_err_o` a one-clock pulse one clock after start, and `lvl_valid_o` stays 0.
- R9: A start raised while a sequence is in progress is ignored. The sequence continues with the values captured at its own start.
- R10: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; all other inputs are captured with it |
| cfg_ishift_i | input | 4 | Number of top address bits dropped |
| cfg_pgsz_i | input | 4 | Page offset width, legal 8 to 15 |
| cfg_fcl_i | input | 1 | Add a function-code level on top |
| cfg_widths_i | input | 16 | Four 4-bit index widths, level 1 in bits 3:0 |
| root_limit_i | input | 15 | Inclusive upper bound on the level 1 index |
| laddr_i | input | 32 | Logical address |
| fcode_i | input | 3 | Function code |
| lvl_valid_o | output | 1 | A level is presented |
| lvl_num_o | output | 3 | Number of the presented level |
| lvl_index_o | output | 15 | Index of the presented level |
| lvl_last_o | output | 1 | Presented level is the page-table level |
| limit_viol_o | output | 1 | Level 1 index exceeds the root limit |
| page_offset_o | output | 15 | Untranslated page offset |
| final_lvl_o | output | 3 | Number of the page-table level |
| cfg_err_o | output | 1 | Invalid configuration pulse |

## Verification
The first level and the error pulse are both due exactly one clock after the edge that samples start. Each further level follows one clock after the one before it, and `lvl_valid_o` drops one clock after the last level. The bench drives inputs on the falling edge, raises start for one clock, and then compares outputs at every following falling edge, one sample per expected level. It does not wait for a result to appear, so an output that is early, late, or held too long shows up as a mismatch at that sample.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned FC_W     = 3;
    localparam int unsigned NUM_ALEV = 4;
    localparam int unsigned WF_W     = 4;
    localparam int unsigned IDX_W    = 15;
    localparam int unsigned OFF_MIN  = 8;
    localparam int unsigned LVL_W    = $clog2(NUM_ALEV + 1);
    localparam int unsigned SUM_W    = 8;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [SUM_W-1:0] sum_t;

    typedef struct packed {
        logic                       busy;
        logic                       err;
        lvl_t                       lvl;
        lvl_t                       fin;
        logic [FC_W-1:0]            fc;
        logic [NUM_ALEV-1:0][IDX_W-1:0] aidx;
        idx_t                       off;
        logic                       viol;
    } seq_t;
endpackage

// File: rtl/tt_cfg_decode.sv
module tt_cfg_decode
    import tt_pkg::*;
(
    input  logic [WF_W-1:0]          ishift_i,
    input  logic [WF_W-1:0]          pgsz_i,
    input  logic [NUM_ALEV*WF_W-1:0] widths_i,
    output logic [NUM_ALEV-1:0][WF_W-1:0] act_w_o,
    output logic [NUM_ALEV-1:0][SUM_W-1:0] shamt_o,
    output lvl_t                     n_alev_o,
    output logic                     err_o
);
    logic          run;
    sum_t          cum;
    logic [WF_W-1:0] w;

    always_comb begin
        run      = 1'b1;
        cum      = SUM_W'(ishift_i);
        n_alev_o = '0;
        w        = '0;
        for (int k = 0; k < NUM_ALEV; k++) begin
            w = widths_i[k*WF_W +: WF_W];
            if (w == '0) run = 1'b0;
            if (run) begin
                cum         = cum + SUM_W'(w);
                act_w_o[k]  = w;
                shamt_o[k]  = SUM_W'(ADDR_W) - cum;
                n_alev_o    = lvl_t'(k + 1);
            end else begin
                act_w_o[k]  = '0;
                shamt_o[k]  = '0;
            end
        end
        err_o = ((cum + SUM_W'(pgsz_i)) != SUM_W'(ADDR_W))
              || (pgsz_i < WF_W'(OFF_MIN))
              || (n_alev_o == '0);
    end
endmodule

// File: rtl/tt_index_slice.sv
module tt_index_slice
    import tt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WF_W-1:0]   width_i,
    input  sum_t              shamt_i,
    output idx_t              idx_o
);
    logic [IDX_W:0] mask;
    idx_t           moved;

    always_comb begin
        mask  = ({{IDX_W{1'b0}}, 1'b1} << width_i) - 1'b1;
        moved = IDX_W'(addr_i >> shamt_i);
        idx_o = moved & mask[IDX_W-1:0];
    end
endmodule

// File: rtl/tt_level_seq.sv
module tt_level_seq
    import tt_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          err_i,
    input  lvl_t                          n_alev_i,
    input  logic                          fcl_i,
    input  logic [FC_W-1:0]               fc_i,
    input  logic [NUM_ALEV-1:0][IDX_W-1:0] aidx_i,
    input  idx_t                          off_i,
    input  idx_t                          limit_i,
    output logic                          valid_o,
    output lvl_t                          num_o,
    output idx_t                          index_o,
    output logic                          last_o,
    output logic                          viol_o,
    output idx_t                          off_o,
    output lvl_t                          fin_o,
    output logic                          err_o
);
    seq_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (st_q.busy) begin
            if (st_q.lvl == st_q.fin) st_d.busy = 1'b0;
            else                      st_d.lvl  = st_q.lvl + 1'b1;
        end else if (start_i) begin
            if (err_i) begin
                st_d.err = 1'b1;
            end else begin
                st_d.busy = 1'b1;
                st_d.lvl  = fcl_i ? lvl_t'(0) : lvl_t'(1);
                st_d.fin  = n_alev_i;
                st_d.fc   = fc_i;
                st_d.aidx = aidx_i;
                st_d.off  = off_i;
                st_d.viol = aidx_i[0] > limit_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        index_o = '0;
        if (st_q.busy) begin
            if (st_q.lvl == '0) index_o = IDX_W'(st_q.fc);
            for (int k = 0; k < NUM_ALEV; k++) begin
                if (st_q.lvl == lvl_t'(k + 1)) index_o = st_q.aidx[k];
            end
        end
        valid_o = st_q.busy;
        num_o   = st_q.busy ? st_q.lvl : '0;
        last_o  = st_q.busy && (st_q.lvl == st_q.fin);
        viol_o  = st_q.busy && (st_q.lvl == lvl_t'(1)) && st_q.viol;
        off_o   = st_q.busy ? st_q.off : '0;
        fin_o   = st_q.busy ? st_q.fin : '0;
        err_o   = st_q.err;
    end
endmodule

// File: rtl/tt_index_sequencer.sv
module tt_index_sequencer
    import tt_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [WF_W-1:0]          cfg_ishift_i,
    input  logic [WF_W-1:0]          cfg_pgsz_i,
    input  logic                     cfg_fcl_i,
    input  logic [NUM_ALEV*WF_W-1:0] cfg_widths_i,
    input  logic [IDX_W-1:0]         root_limit_i,
    input  logic [ADDR_W-1:0]        laddr_i,
    input  logic [FC_W-1:0]          fcode_i,
    output logic                     lvl_valid_o,
    output logic [LVL_W-1:0]         lvl_num_o,
    output logic [IDX_W-1:0]         lvl_index_o,
    output logic                     lvl_last_o,
    output logic                     limit_viol_o,
    output logic [IDX_W-1:0]         page_offset_o,
    output logic [LVL_W-1:0]         final_lvl_o,
    output logic                     cfg_err_o
);
    logic [NUM_ALEV-1:0][WF_W-1:0]  act_w;
    logic [NUM_ALEV-1:0][SUM_W-1:0] shamt;
    logic [NUM_ALEV-1:0][IDX_W-1:0] aidx;
    lvl_t                           n_alev;
    logic                           cfg_err;
    idx_t                           off;

    tt_cfg_decode u_dec (
        .ishift_i (cfg_ishift_i),
        .pgsz_i   (cfg_pgsz_i),
        .widths_i (cfg_widths_i),
        .act_w_o  (act_w),
        .shamt_o  (shamt),
        .n_alev_o (n_alev),
        .err_o    (cfg_err)
    );

    for (genvar g = 0; g < NUM_ALEV; g++) begin : g_lvl
        tt_index_slice u_slice (
            .addr_i  (laddr_i),
            .width_i (act_w[g]),
            .shamt_i (shamt[g]),
            .idx_o   (aidx[g])
        );
    end

    tt_index_slice u_off (
        .addr_i  (laddr_i),
        .width_i (cfg_pgsz_i),
        .shamt_i ('0),
        .idx_o   (off)
    );

    tt_level_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .err_i    (cfg_err),
        .n_alev_i (n_alev),
        .fcl_i    (cfg_fcl_i),
        .fc_i     (fcode_i),
        .aidx_i   (aidx),
        .off_i    (off),
        .limit_i  (root_limit_i),
        .valid_o  (lvl_valid_o),
        .num_o    (lvl_num_o),
        .index_o  (lvl_index_o),
        .last_o   (lvl_last_o),
        .viol_o   (limit_viol_o),
        .off_o    (page_offset_o),
        .fin_o    (final_lvl_o),
        .err_o    (cfg_err_o)
    );
endmodule

// File: rtl/tt_index_checker.sv
module tt_index_checker
    import tt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             lvl_valid_o,
    input logic [LVL_W-1:0] lvl_num_o,
    input logic [IDX_W-1:0] lvl_index_o,
    input logic             lvl_last_o,
    input logic             limit_viol_o,
    input logic [IDX_W-1:0] page_offset_o,
    input logic [LVL_W-1:0] final_lvl_o,
    input logic             cfg_err_o
);
    p_valid_needs_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_valid_o) |-> $past(start_i));

    p_level_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_valid_o && !lvl_last_o) |=> (lvl_valid_o && lvl_num_o == $past(lvl_num_o) + 1'b1));

    p_end_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_last_o |=> !lvl_valid_o);

    p_fc_level_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_valid_o && lvl_num_o == '0) |-> (lvl_index_o < IDX_W'(1 << FC_W)));

    p_last_is_final_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_last_o |-> (lvl_valid_o && lvl_num_o == final_lvl_o));

    p_offset_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_valid_o && !lvl_last_o) |=> ($stable(page_offset_o) && $stable(final_lvl_o)));

    p_viol_at_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        limit_viol_o |-> (lvl_valid_o && lvl_num_o == LVL_W'(1)));

    p_err_no_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (!lvl_valid_o && $past(start_i)));
endmodule

bind tt_index_sequencer tt_index_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .lvl_valid_o   (lvl_valid_o),
    .lvl_num_o     (lvl_num_o),
    .lvl_index_o   (lvl_index_o),
    .lvl_last_o    (lvl_last_o),
    .limit_viol_o  (limit_viol_o),
    .page_offset_o (page_offset_o),
    .final_lvl_o   (final_lvl_o),
    .cfg_err_o     (cfg_err_o)
);

// File: tb/tt_index_sequencer_bench.sv
`timescale 1ns/1ps
module tt_index_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  cfg_ishift_i = '0;
    logic [3:0]  cfg_pgsz_i = '0;
    logic        cfg_fcl_i = 1'b0;
    logic [15:0] cfg_widths_i = '0;
    logic [14:0] root_limit_i = '0;
    logic [31:0] laddr_i = '0;
    logic [2:0]  fcode_i = '0;
    logic        lvl_valid_o, lvl_last_o, limit_viol_o, cfg_err_o;
    logic [2:0]  lvl_num_o, final_lvl_o;
    logic [14:0] lvl_index_o, page_offset_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tt_index_sequencer u_tt_index_sequencer (.*);

    // vector: {ishift, pgsz, fcl, widths, fc, limit, addr}
    localparam int NV = 7;
    localparam logic [74:0] VEC [NV] = '{
        {4'd0, 4'd12, 1'b0, 16'h00AA, 3'd5, 15'h7FFF, 32'hDEADBEEF},
        {4'd0, 4'd8,  1'b1, 16'h0888, 3'd6, 15'h0010, 32'h12345678},
        {4'd4, 4'd12, 1'b1, 16'h4444, 3'd3, 15'h0009, 32'hA5C3F00D},
        {4'd8, 4'd13, 1'b0, 16'h370B, 3'd1, 15'h7FFF, 32'hCAFEBABE},
        {4'd0, 4'd12, 1'b0, 16'h0555, 3'd2, 15'h7FFF, 32'h0F0F0F0F},
        {4'd2, 4'd15, 1'b0, 16'h000F, 3'd7, 15'h1000, 32'h3FFF8000},
        {4'd0, 4'd7,  1'b0, 16'h05AA, 3'd0, 15'h7FFF, 32'h89ABCDEF}
    };

    logic [14:0] m_idx [5];
    int          m_fin;
    logic        m_err;
    logic [14:0] m_off;
    logic        m_viol;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model(input logic [74:0] v);
        int pos, sum, ish, pg;
        logic [31:0] a;
        logic [15:0] w;
        ish = int'(v[74:71]); pg = int'(v[70:67]); w = v[65:50]; a = v[31:0];
        pos = 31 - ish; sum = ish + pg; m_fin = 0;
        for (int k = 0; k < 5; k++) m_idx[k] = '0;
        m_idx[0] = {12'd0, v[49:47]};
        for (int k = 0; k < 4; k++) begin
            int wk;
            wk = int'(w[4*k +: 4]);
            if (wk == 0) break;
            m_fin = k + 1; sum += wk;
            for (int b = 0; b < wk; b++) begin
                m_idx[k+1] = {m_idx[k+1][13:0], a[pos]};
                pos--;
            end
        end
        m_err = (sum != 32) || (pg < 8) || (m_fin == 0);
        m_off = '0;
        for (int b = 0; b < pg; b++) m_off[b] = a[b];
        m_viol = m_idx[1] > v[46:32];
    endtask

    task automatic run_vec(input logic [74:0] v, input bit poke);
        int first;
        model(v);
        @(negedge clk);
        {cfg_ishift_i, cfg_pgsz_i, cfg_fcl_i, cfg_widths_i, fcode_i, root_limit_i, laddr_i} = v;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        laddr_i = ~laddr_i; fcode_i = ~fcode_i; cfg_fcl_i = ~cfg_fcl_i;
        if (m_err) begin
            chk("R8 err pulse", 32'(cfg_err_o), 1);
            chk("R8 no valid", 32'(lvl_valid_o), 0);
            @(negedge clk);
            chk("R8 pulse ends", 32'(cfg_err_o), 0);
            chk("R8 still no valid", 32'(lvl_valid_o), 0);
            return;
        end
        chk("R8 no err", 32'(cfg_err_o), 0);
        first = v[66] ? 0 : 1;
        for (int lv = first; lv <= m_fin; lv++) begin
            chk("R1 valid", 32'(lvl_valid_o), 1);
            chk("R1 level number", 32'(lvl_num_o), 32'(lv));
            if (lv == 0) chk("R2 fc index", 32'(lvl_index_o), 32'(m_idx[0]));
            else         chk("R3 addr index", 32'(lvl_index_o), 32'(m_idx[lv]));
            chk("R5 last flag", 32'(lvl_last_o), 32'(lv == m_fin));
            chk("R5 R4 final level", 32'(final_lvl_o), 32'(m_fin));
            chk("R6 offset", 32'(page_offset_o), 32'(m_off));
            chk("R7 limit flag", 32'(limit_viol_o), 32'(lv == 1 && m_viol));
            if (poke && lv == first + 1) begin
                start_i = 1'b1;  // R9: ignored while busy
                laddr_i = 32'h0; cfg_widths_i = 16'h0001;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk("R1 R9 valid drops after last", 32'(lvl_valid_o), 0);
    endtask

    initial begin
        #1000000;
        errors++; checks++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [74:0] v;
        repeat (3) @(negedge clk);
        chk("R10 reset valid", 32'(lvl_valid_o), 0);
        chk("R10 reset err", 32'(cfg_err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle valid", 32'(lvl_valid_o), 0);
        chk("R10 idle outputs", 32'({lvl_num_o, lvl_index_o, lvl_last_o, limit_viol_o}), 0);
        chk("R10 idle offset", 32'({page_offset_o, final_lvl_o}), 0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);

        // R9: second start during a five-level sequence
        run_vec(VEC[2], 1'b1);

        // R7 boundary: limit equal to index, then one below
        v = VEC[5];
        model(v);
        v[46:32] = m_idx[1];
        run_vec(v, 1'b0);
        v[46:32] = m_idx[1] - 1'b1;
        run_vec(v, 1'b0);

        // R4: widths beyond first zero ignored, including an over-sum set
        v = VEC[3]; v[65:50] = 16'hFF0B;
        run_vec(v, 1'b0);

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule